// File: doc/BRIEF.md
# Sync-Word Frame Alignment Tracker

This block follows frame alignment on a serial receive stream. Every frame opens with a programmed sync word. The tracker starts unaligned and compares the recent bits against that word at every bit position. After a first exact hit it confirms the alignment over further frames. Once locked, it checks the word once per frame at the expected position.

When a locked frame misses, the tracker enters an errored state and counts missed frames. Each errored frame also gets a similarity score: the number of bit positions where the received word equals the programmed word at the expected position. A score below the programmed threshold makes the search window wider by one quat (two bits) on each side. An exact hit anywhere inside the window restores lock and moves the frame timing to the position found. Too many missed frames in a row drop the tracker back to the unaligned search.

Received bits arrive on a valid/ready stream of one bit per beat. The tracker never applies back-pressure: `rx_ready` is always high, and a bit is taken on every clock where `rx_valid` is high. Clocks with `rx_valid` low change nothing. The sync pattern, threshold and counts are static settings and should be changed only while reset is asserted. `FRAME_LEN` must exceed `SYNC_W + 4*MAX_Q`.

Top module: `sync_frame_tracker`

## Requirements
- R1: After reset, `sync_state` is 0, `err_count` is 0, `frame_start` is low and `rx_ready` is high.
- R2: A bit is consumed only on a clock with `rx_valid` high, and `rx_ready` is always high. While `rx_valid` is low, the state, the counter and the frame timing are held and no `frame_start` is produced.
- R3: `sync_state` is encoded as 0 = lost, 1 = confirming, 2 = locked, 3 = errored. The word is compared with its first received bit against `sync_pattern[SYNC_W-1]`. While lost, every consumed bit is tested. An exact hit moves the tracker to confirming, or straight to locked if `acq_count` is at most 1. While confirming, an exact hit at the next frame position counts toward `acq_count` consecutive hits, which give locked. A miss returns the tracker to lost.
- R4: While locked, an exact hit at the expected position keeps the lock. Any miss moves the tracker to errored with `err_count` = 1.
- R5: The similarity score is taken at the expected position. A score of at least `match_thresh` keeps the search window unchanged. A lower score widens the window by one quat on each side, up to `MAX_Q` quats. The window starts at zero width when the errored state is entered from lock with a passing score, and at one quat with a failing score.
- R6: While errored, an exact hit at any candidate inside the window returns the tracker to locked with `err_count` = 0. The window closes, and the next frame is expected one frame length after the hit position. The expected position is preferred, then the nearer offset, then the earlier of two equal offsets.
- R7: Every errored or locked frame without an exact hit adds one to the miss count. When the count reaches `loss_count`, the tracker goes to lost with `err_count` = 0. `err_count` is nonzero only in the errored state.
- R8: `frame_start` pulses for one clock after each frame evaluation that leaves the tracker locked or errored, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive bit valid |
| rx_bit | input | 1 | Receive bit |
| rx_ready | output | 1 | Always high, no back-pressure |
| sync_pattern | input | SYNC_W | Programmed sync word, first bit in MSB |
| match_thresh | input | $clog2(SYNC_W+1) | Minimum similarity score for a tolerable word |
| acq_count | input | CRIT_W | Exact hits needed to lock |
| loss_count | input | CRIT_W | Missed frames that drop the lock |
| sync_state | output | 2 | Tracker state (encoding in R3) |
| err_count | output | CRIT_W | Missed frames in the current errored run |
| frame_start | output | 1 | One-clock strobe per aligned frame |

## Verification
The bench builds the tracker with `FRAME_LEN` = 40 and `MAX_Q` = 2. A full widening sequence, a frame loss and several recoveries therefore fit into a few thousand clocks. With two quats, the window reaches its cap in two weak frames, so the bench can reach a recovery at the outermost candidate (four bits early) and the cap itself. Frames are stretched or shortened to place the word off its expected position. Single- and multi-bit flips select which side of the threshold each errored frame falls on. Idle beats in the stream exercise the enable.

// File: rtl/sync_trk_pkg.sv
package sync_trk_pkg;
  typedef enum logic [1:0] {
    ST_LOST = 2'd0,
    ST_HUNT = 2'd1,
    ST_LOCK = 2'd2,
    ST_ERR  = 2'd3
  } trk_state_e;
endpackage

// File: rtl/sync_hist_reg.sv
module sync_hist_reg #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] win_next
);
  logic [W-1:0] hist;

  // newest bit at index 0; window includes the bit being taken this clock
  assign win_next = {hist[W-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (!rst_n)        hist <= '0;
    else if (shift_en) hist <= win_next;
  end
endmodule

// File: rtl/sync_corr.sv
module sync_corr #(
  parameter int SYNC_W = 14,
  parameter int MAX_Q  = 3,
  localparam int MAXD  = 2 * MAX_Q,
  localparam int W     = SYNC_W + 2 * MAXD,
  localparam int NCAND = 2 * MAX_Q + 1,
  localparam int RAD_W = $clog2(MAX_Q + 1),
  localparam int OFF_W = $clog2(MAXD + 1) + 1,
  localparam int MC_W  = $clog2(SYNC_W + 1)
) (
  input  logic [W-1:0]            win,
  input  logic [SYNC_W-1:0]       pattern,
  input  logic [RAD_W-1:0]        radius,
  output logic                    exact_ctr,
  output logic                    exact_hit,
  output logic signed [OFF_W-1:0] hit_off,
  output logic [MC_W-1:0]         match_cnt
);
  logic [NCAND-1:0] exact;

  // candidate k sits at offset d = 2*(k-MAX_Q) bits from the expected end
  for (genvar k = 0; k < NCAND; k++) begin : g_cand
    localparam int BASE = 2 * (2 * MAX_Q - k);
    assign exact[k] = (win[BASE +: SYNC_W] == pattern);
  end

  assign exact_ctr = exact[MAX_Q];
  assign match_cnt = MC_W'($countones(~(win[MAXD +: SYNC_W] ^ pattern)));

  // nearest candidate first, earlier before later at equal distance
  always_comb begin
    exact_hit = 1'b0;
    hit_off   = '0;
    for (int j = 0; j <= MAX_Q; j++) begin
      if (!exact_hit && (j <= int'(radius))) begin
        if (exact[MAX_Q - j]) begin
          exact_hit = 1'b1;
          hit_off   = OFF_W'(-2 * j);
        end else if (exact[MAX_Q + j]) begin
          exact_hit = 1'b1;
          hit_off   = OFF_W'(2 * j);
        end
      end
    end
  end
endmodule

// File: rtl/sync_trk_fsm.sv
module sync_trk_fsm
  import sync_trk_pkg::*;
#(
  parameter int FRAME_LEN = 4704,
  parameter int MAX_Q     = 3,
  parameter int SYNC_W    = 14,
  parameter int CRIT_W    = 4,
  localparam int MAXD     = 2 * MAX_Q,
  localparam int RAD_W    = $clog2(MAX_Q + 1),
  localparam int OFF_W    = $clog2(MAXD + 1) + 1,
  localparam int MC_W     = $clog2(SYNC_W + 1),
  localparam int TE_W     = $clog2(FRAME_LEN + MAXD)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bit_en,
  input  logic                    exact_ctr,
  input  logic                    exact_hit,
  input  logic signed [OFF_W-1:0] hit_off,
  input  logic [MC_W-1:0]         match_cnt,
  input  logic [MC_W-1:0]         thresh,
  input  logic [CRIT_W-1:0]       acq,
  input  logic [CRIT_W-1:0]       loss,
  output trk_state_e              state,
  output logic [CRIT_W-1:0]       err_cnt,
  output logic [RAD_W-1:0]        radius,
  output logic                    frame_start
);
  logic [CRIT_W-1:0] hits;
  logic [TE_W-1:0]   to_eval;
  logic              at_eval, tolerable;
  logic [CRIT_W:0]   hits_inc, err_inc;
  logic [RAD_W-1:0]  radius_wide;

  assign at_eval     = (to_eval == '0);
  assign tolerable   = (match_cnt >= thresh);
  assign hits_inc    = {1'b0, hits} + {{CRIT_W{1'b0}}, 1'b1};
  assign err_inc     = {1'b0, err_cnt} + {{CRIT_W{1'b0}}, 1'b1};
  assign radius_wide = tolerable ? radius :
                       (radius < RAD_W'(MAX_Q)) ? radius + 1'b1 : radius;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_LOST;
      err_cnt     <= '0;
      radius      <= '0;
      hits        <= '0;
      to_eval     <= '0;
      frame_start <= 1'b0;
    end else begin
      frame_start <= 1'b0;
      if (bit_en) begin
        if (!at_eval) to_eval <= to_eval - 1'b1;
        unique case (state)
          ST_LOST: begin
            if (exact_ctr) begin
              to_eval <= TE_W'(FRAME_LEN - 1);
              hits    <= CRIT_W'(1);
              if (acq <= CRIT_W'(1)) begin
                state       <= ST_LOCK;
                frame_start <= 1'b1;
              end else begin
                state <= ST_HUNT;
              end
            end
          end
          ST_HUNT: begin
            if (at_eval) begin
              to_eval <= TE_W'(FRAME_LEN - 1);
              if (exact_ctr) begin
                hits <= hits_inc[CRIT_W-1:0];
                if (hits_inc >= {1'b0, acq}) begin
                  state       <= ST_LOCK;
                  frame_start <= 1'b1;
                end
              end else begin
                state <= ST_LOST;
                hits  <= '0;
              end
            end
          end
          ST_LOCK: begin
            if (at_eval) begin
              to_eval <= TE_W'(FRAME_LEN - 1);
              if (exact_ctr) begin
                frame_start <= 1'b1;
              end else if (loss <= CRIT_W'(1)) begin
                state   <= ST_LOST;
                err_cnt <= '0;
              end else begin
                state       <= ST_ERR;
                err_cnt     <= CRIT_W'(1);
                radius      <= tolerable ? '0 : RAD_W'(1);
                frame_start <= 1'b1;
              end
            end
          end
          ST_ERR: begin
            if (at_eval) begin
              if (exact_hit) begin
                state       <= ST_LOCK;
                err_cnt     <= '0;
                radius      <= '0;
                to_eval     <= TE_W'(FRAME_LEN - 1 + int'(hit_off));
                frame_start <= 1'b1;
              end else begin
                to_eval <= TE_W'(FRAME_LEN - 1);
                if (err_inc >= {1'b0, loss}) begin
                  state   <= ST_LOST;
                  err_cnt <= '0;
                  radius  <= '0;
                end else begin
                  err_cnt     <= err_inc[CRIT_W-1:0];
                  radius      <= radius_wide;
                  frame_start <= 1'b1;
                end
              end
            end
          end
          default: state <= ST_LOST;
        endcase
      end
    end
  end
endmodule

// File: rtl/sync_frame_tracker.sv
module sync_frame_tracker
  import sync_trk_pkg::*;
#(
  parameter int SYNC_W    = 14,
  parameter int FRAME_LEN = 4704,
  parameter int MAX_Q     = 3,
  parameter int CRIT_W    = 4,
  localparam int MAXD     = 2 * MAX_Q,
  localparam int W        = SYNC_W + 2 * MAXD,
  localparam int RAD_W    = $clog2(MAX_Q + 1),
  localparam int OFF_W    = $clog2(MAXD + 1) + 1,
  localparam int MC_W     = $clog2(SYNC_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_bit,
  output logic              rx_ready,
  input  logic [SYNC_W-1:0] sync_pattern,
  input  logic [MC_W-1:0]   match_thresh,
  input  logic [CRIT_W-1:0] acq_count,
  input  logic [CRIT_W-1:0] loss_count,
  output logic [1:0]        sync_state,
  output logic [CRIT_W-1:0] err_count,
  output logic              frame_start
);
  logic [W-1:0]            win;
  logic [RAD_W-1:0]        radius;
  logic                    exact_ctr, exact_hit;
  logic signed [OFF_W-1:0] hit_off;
  logic [MC_W-1:0]         match_cnt;
  trk_state_e              state;
  logic                    take;

  assign rx_ready   = 1'b1;
  assign take       = rx_valid;
  assign sync_state = state;

  sync_hist_reg #(.W(W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (take),
    .bit_in   (rx_bit),
    .win_next (win)
  );

  sync_corr #(.SYNC_W(SYNC_W), .MAX_Q(MAX_Q)) u_corr (
    .win       (win),
    .pattern   (sync_pattern),
    .radius    (radius),
    .exact_ctr (exact_ctr),
    .exact_hit (exact_hit),
    .hit_off   (hit_off),
    .match_cnt (match_cnt)
  );

  sync_trk_fsm #(
    .FRAME_LEN (FRAME_LEN),
    .MAX_Q     (MAX_Q),
    .SYNC_W    (SYNC_W),
    .CRIT_W    (CRIT_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (take),
    .exact_ctr   (exact_ctr),
    .exact_hit   (exact_hit),
    .hit_off     (hit_off),
    .match_cnt   (match_cnt),
    .thresh      (match_thresh),
    .acq         (acq_count),
    .loss        (loss_count),
    .state       (state),
    .err_cnt     (err_count),
    .radius      (radius),
    .frame_start (frame_start)
  );
endmodule

// File: rtl/sync_frame_tracker_chk.sv
module sync_frame_tracker_chk #(
  parameter int CRIT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic [CRIT_W-1:0] loss_count,
  input logic [1:0]        sync_state,
  input logic [CRIT_W-1:0] err_count,
  input logic              frame_start
);
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> ($stable(sync_state) && $stable(err_count)));  // R2

  AST_STROBE_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> $past(rx_valid));  // R8

  AST_STROBE_ONLY_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (sync_state == 2'd2 || sync_state == 2'd3));  // R8

  AST_COUNT_ONLY_ERRORED: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_state != 2'd3) |-> (err_count == '0));  // R7

  AST_COUNT_BELOW_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_state == 2'd3) |-> (err_count != '0 && err_count < loss_count));  // R7

  AST_LOST_NEVER_ERRORED: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_state == 2'd0) |=> (sync_state != 2'd3));  // R3
endmodule

bind sync_frame_tracker sync_frame_tracker_chk #(.CRIT_W(CRIT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_valid    (rx_valid),
  .loss_count  (loss_count),
  .sync_state  (sync_state),
  .err_count   (err_count),
  .frame_start (frame_start)
);

// File: tb/sync_frame_tracker_tb.sv
`timescale 1ns/1ps
module sync_frame_tracker_tb;
  localparam int FL   = 40;
  localparam int MQ   = 2;
  localparam int SW   = 14;
  localparam logic [SW-1:0] PAT = 14'h2C8D;  // first and last bits are 1

  logic clk = 1'b0, rst_n = 1'b0, rx_valid = 1'b0, rx_bit = 1'b0;
  logic rx_ready, frame_start;
  logic [3:0] match_thresh = 4'd12, acq_count = 4'd2, loss_count = 4'd6;
  logic [1:0] sync_state;
  logic [3:0] err_count;

  int n_chk = 0, n_err = 0, fs_seen = 0, gap_ctr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sync_frame_tracker #(.SYNC_W(SW), .FRAME_LEN(FL), .MAX_Q(MQ), .CRIT_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .rx_ready(rx_ready), .sync_pattern(PAT), .match_thresh(match_thresh),
    .acq_count(acq_count), .loss_count(loss_count), .sync_state(sync_state),
    .err_count(err_count), .frame_start(frame_start)
  );

  // fields: [25] word absent, [24:11] bit flips, [10:6] signed stretch of
  // the gap after this word, [5:4] expected state, [3:0] expected count
  localparam logic [25:0] VEC [0:24] = '{
    {1'b0, 14'h0000, 5'd0,  2'd1, 4'd0},
    {1'b0, 14'h0000, 5'd0,  2'd2, 4'd0},
    {1'b0, 14'h0000, 5'd0,  2'd2, 4'd0},
    {1'b0, 14'h0040, 5'd0,  2'd3, 4'd1},
    {1'b0, 14'h0000, 5'd0,  2'd2, 4'd0},
    {1'b0, 14'h00E0, 5'd2,  2'd3, 4'd1},
    {1'b0, 14'h0000, 5'd0,  2'd2, 4'd0},
    {1'b0, 14'h0000, 5'd0,  2'd2, 4'd0},
    {1'b1, 14'h0000, 5'd0,  2'd3, 4'd1},
    {1'b1, 14'h0000, 5'd0,  2'd3, 4'd2},
    {1'b1, 14'h0000, 5'd0,  2'd3, 4'd3},
    {1'b1, 14'h0000, 5'd0,  2'd3, 4'd4},
    {1'b1, 14'h0000, 5'd0,  2'd3, 4'd5},
    {1'b1, 14'h0000, 5'd0,  2'd0, 4'd0},
    {1'b0, 14'h0000, 5'd0,  2'd1, 4'd0},
    {1'b0, 14'h0300, 5'd0,  2'd0, 4'd0},
    {1'b0, 14'h0000, 5'd0,  2'd1, 4'd0},
    {1'b0, 14'h0000, 5'd0,  2'd2, 4'd0},
    {1'b1, 14'h0000, 5'd0,  2'd3, 4'd1},
    {1'b1, 14'h0000, 5'h1C, 2'd3, 4'd2},
    {1'b0, 14'h0000, 5'd0,  2'd2, 4'd0},
    {1'b0, 14'h0000, 5'd0,  2'd2, 4'd0},
    {1'b0, 14'h0040, 5'd0,  2'd3, 4'd1},
    {1'b0, 14'h0040, 5'd0,  2'd3, 4'd2},
    {1'b0, 14'h0000, 5'd0,  2'd2, 4'd0}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 1, 14, 15, 16, 17: return "R3";
      2, 3:                 return "R4";
      5, 8, 9, 18, 19, 22, 23: return "R5";
      4, 6, 7, 20, 21, 24:  return "R6";
      default:              return "R7";
    endcase
  endfunction

  task automatic check_eq(input int act, input int exp, input string tag, input string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (frame_start) fs_seen++;
  endtask

  task automatic send_bit(input logic b);
    tick();
    if (gap_ctr == 4) begin
      rx_valid = 1'b0;
      rx_bit   = ~b;
      gap_ctr  = 0;
      tick();
    end else begin
      gap_ctr++;
    end
    rx_valid = 1'b1;
    rx_bit   = b;
  endtask

  task automatic send_frame(input logic absent, input logic [SW-1:0] flip, input int adj);
    logic [SW-1:0] word;
    word = absent ? '0 : (PAT ^ flip);
    for (int i = SW - 1; i >= 0; i--) send_bit(word[i]);
    for (int n = 0; n < FL - SW + adj; n++) send_bit(1'b0);
    tick();
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R1-watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_eq(sync_state, 0, "R1", "reset state");
    check_eq(err_count, 0, "R1", "reset count");
    check_eq(frame_start, 0, "R1", "reset strobe");
    check_eq(rx_ready, 1, "R2", "ready");
    rst_n = 1'b1;

    for (int v = 0; v < 25; v++) begin
      fs_seen = 0;
      send_frame(VEC[v][25], VEC[v][24:11], int'($signed(VEC[v][10:6])));
      check_eq(sync_state, int'(VEC[v][5:4]), tag_of(v), $sformatf("vec %0d state", v));
      check_eq(err_count, int'(VEC[v][3:0]), tag_of(v), $sformatf("vec %0d count", v));
      check_eq(fs_seen, (VEC[v][5:4] >= 2'd2) ? 1 : 0, "R8", $sformatf("vec %0d strobes", v));
    end

    // R2: idle beats with toggling data change nothing
    fs_seen = 0;
    for (int c = 0; c < 100; c++) begin
      tick();
      rx_valid = 1'b0;
      rx_bit   = c[0];
    end
    check_eq(sync_state, 2, "R2", "state held while idle");
    check_eq(fs_seen, 0, "R2", "no strobe while idle");
    send_frame(1'b0, '0, 0);
    check_eq(sync_state, 2, "R2", "timing held across idle");

    // R1: reset in mid-stream
    @(negedge clk);
    rst_n = 1'b0;
    acq_count  = 4'd1;
    loss_count = 4'd1;
    repeat (2) @(negedge clk);
    check_eq(sync_state, 0, "R1", "state after reset");
    check_eq(err_count, 0, "R1", "count after reset");
    check_eq(frame_start, 0, "R1", "strobe after reset");
    rst_n = 1'b1;

    // R3: single-hit acquisition; R7: single-miss loss
    fs_seen = 0;
    send_frame(1'b0, '0, 0);
    check_eq(sync_state, 2, "R3", "lock on first hit");
    check_eq(fs_seen, 1, "R8", "strobe at direct lock");
    send_frame(1'b1, '0, 0);
    check_eq(sync_state, 0, "R7", "loss on first miss");
    check_eq(err_count, 0, "R7", "count after direct loss");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule